// File: doc/BRIEF.md
# Comparator Timer Channel

This block is a single channel of an event-timer array. It stores a channel configuration word, a visible comparator, a hidden period value and a message-route word. Each cycle it compares a shared 64-bit free-running count against an internal target. When the count reaches the target, the channel raises a match event. The match drives an interrupt request and, for level-type channels, a one-cycle pulse that sets the channel's bit in the shared status register. The status register itself lives outside the channel.

A channel runs once (one-shot) or repeats (periodic). It can also be forced into a 32-bit mode, which is useful for software written for a narrower counter. In 32-bit mode the channel builds its target from the current count with the low half replaced. For a one-shot target that lies beyond the next 32-bit rollover, the channel first fires at the rollover point and then fires again at the real target. Software reaches the registers through a write strobe with a 5-bit offset, where bit 2 picks the upper half, and through a combinational read port that uses the same offset coding.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the registers read as follows:
  - configuration low half: 0x30, with bit 15 also set when the message capability parameter is 1;
  - configuration high half: the route-capability parameter;
  - both comparator halves: 0xFFFFFFFF;
  - route word: 0;
  - `irq_o` and `sts_set_o`: 0.
- R2: A write to the configuration low half (offset 0x00) changes only the bits in mask 0x7F4E. The other bits keep their value. Writes to the high half (offset 0x04) change nothing.
- R3: A one-shot 64-bit channel fires when the count is at or past the target. In edge mode (configuration bit 1 = 0), `irq_o` pulses high for one cycle, in the cycle after the count equals the target. The channel then stays idle until it is rewritten.
- R4: A match in level mode (bit 1 = 1) pulses `sts_set_o` for one cycle whether or not the interrupt enable (bit 2) is set. A match in edge mode never pulses `sts_set_o`. `irq_o` asserts only when bit 2 is 1.
- R5: In periodic mode (bit 3 = 1), a comparator write (offset 0x08/0x0C) always loads the hidden period. It changes the visible comparator only when value-set (bit 6) is 1. Bit 6 reads 0 after any accepted comparator write.
- R6: On a periodic match with a nonzero period, the target advances by the period until it is ahead of the count. The channel fires again at each new target, and the visible comparator shows the advanced target.
- R7: In 32-bit mode (bit 8 = 1):
  - the upper halves of the comparator and the period read and stay 0;
  - writes to the comparator high half are ignored;
  - the target is the current count with its low 32 bits replaced by the comparator, with 2^32 added when that result is below the count.
- R8: In 32-bit one-shot mode, when the target lies beyond the next 32-bit rollover, the channel fires once at the rollover point and once more at the target.
- R9: In level mode, `irq_o` stays high until `sts_clr_i` pulses. It drops in the cycle after a configuration write that selects edge mode.
- R10: In level mode, a configuration write that sets bit 2 while `sts_pend_i` is 1 and the global enable is 1 raises `irq_o` in the next cycle, without a new match.
- R11: While `gbl_en_i` is 0 the channel produces no match events. Lowering `gbl_en_i` drops `irq_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Shared main count value |
| gbl_en_i | input | 1 | Global enable for counting and interrupts |
| sts_pend_i | input | 1 | This channel's bit of the shared status register |
| sts_clr_i | input | 1 | Pulse: the status bit of this channel is being cleared |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write offset: [4:3] register (0 config, 1 comparator, 2 route), [2] upper half |
| wr_data_i | input | 32 | Write data for the selected half |
| rd_addr_i | input | 5 | Read offset, same coding as the write offset |
| rd_data_o | output | 32 | Read data for the selected half |
| irq_o | output | 1 | Interrupt request, held for level, one-cycle pulse for edge |
| sts_set_o | output | 1 | One-cycle pulse that sets the shared status bit |

## Verification
The hardest condition to reach is the double event of a 32-bit one-shot channel whose target has to be pushed past the next rollover. The stimulus places the count just above a low target within one 32-bit epoch, writes the comparator so that the target moves into the following epoch, and then jumps the count to a few ticks before the rollover. That way both the rollover event and the real event fall inside a short run.

The periodic catch-up is exercised with a period of 0x40 across three back-to-back matches. The immediate assertion on enabling with a pending status is checked in the exact cycle after the write, before any fresh match could raise the request.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int unsigned CW = 64;        // counter and register width
    localparam int unsigned HW = CW / 2;    // bus half width
    localparam int unsigned AW = 5;         // channel offset width

    localparam logic [CW-1:0] CFG_WMASK = 64'h0000_0000_0000_7F4E;

    localparam int unsigned B_LVL  = 1;
    localparam int unsigned B_IEN  = 2;
    localparam int unsigned B_PER  = 3;
    localparam int unsigned B_VSET = 6;
    localparam int unsigned B_M32  = 8;

    typedef enum logic [1:0] {
        RS_CFG   = 2'd0,
        RS_CMP   = 2'd1,
        RS_ROUTE = 2'd2,
        RS_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CW-1:0] cfg;
        logic [CW-1:0] cmp;
        logic [CW-1:0] per;
        logic [CW-1:0] route;
        logic [CW-1:0] tgt;
        logic          wrap;
        logic          armed;
        logic          adv;
        logic          gen;
        logic          irq;
        logic          sts;
    } chan_st_t;

    function automatic logic [CW-1:0] put_half(input logic [CW-1:0] old,
                                               input logic          hi,
                                               input logic [HW-1:0] val);
        logic [CW-1:0] r;
        r = old;
        if (hi) r[CW-1:HW] = val;
        else    r[HW-1:0]  = val;
        return r;
    endfunction

    function automatic logic [CW-1:0] low_only(input logic [CW-1:0] v);
        return {{HW{1'b0}}, v[HW-1:0]};
    endfunction

endpackage

// File: rtl/ctc_target.sv
module ctc_target #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         m32_i,
    input  logic         per_i,
    output logic [W-1:0] tgt_o,
    output logic         wrap_o
);
    localparam int unsigned H = W / 2;
    localparam logic [W-1:0] EPOCH = {{(W-1){1'b0}}, 1'b1} << H;
    localparam logic [H-1:0] ONE_H = {{(H-1){1'b0}}, 1'b1};

    logic [W-1:0] spliced;
    logic [W-1:0] nxt_wrap;

    always_comb begin
        spliced = {cnt_i[W-1:H], cmp_i[H-1:0]};
        if (spliced < cnt_i) spliced = spliced + EPOCH;
        nxt_wrap = {cnt_i[W-1:H] + ONE_H, {H{1'b0}}};
        tgt_o    = m32_i ? spliced : cmp_i;
        wrap_o   = m32_i && !per_i && (spliced > nxt_wrap);
    end
endmodule

// File: rtl/ctc_match.sv
module ctc_match #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] arm_i,
    input  logic [W-1:0] nxt_i,
    output logic         reached_o,
    output logic         ahead_o
);
    logic [W-1:0] d_reach;
    logic [W-1:0] d_ahead;

    // signed differences keep the compare valid across counter rollover
    assign d_reach   = cnt_i - arm_i;
    assign d_ahead   = nxt_i - cnt_i;
    assign reached_o = !d_reach[W-1];
    assign ahead_o   = !d_ahead[W-1] && (d_ahead != '0);
endmodule

// File: rtl/ctc_rdmux.sv
module ctc_rdmux
    import ctc_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] cfg_i,
    input  logic [CW-1:0] cmp_i,
    input  logic [CW-1:0] route_i,
    output logic [HW-1:0] data_o
);
    logic [CW-1:0] word;

    always_comb begin
        unique case (reg_sel_e'(addr_i[4:3]))
            RS_CFG:   word = cfg_i;
            RS_CMP:   word = cmp_i;
            RS_ROUTE: word = route_i;
            default:  word = '0;
        endcase
        data_o = addr_i[2] ? word[CW-1:HW] : word[HW-1:0];
    end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import ctc_pkg::*;
#(
    parameter logic [HW-1:0] ROUTE_CAP = 32'h00F0_0000,
    parameter logic          MSG_CAP   = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] count_i,
    input  logic          gbl_en_i,
    input  logic          sts_pend_i,
    input  logic          sts_clr_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [HW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [HW-1:0] rd_data_o,
    output logic          irq_o,
    output logic          sts_set_o
);
    localparam logic [CW-1:0] CFG_RST =
        {ROUTE_CAP, 16'h0000, MSG_CAP, 9'h000, 2'b11, 4'h0};

    chan_st_t st_q, st_d;

    logic          wr_hi;
    reg_sel_e      wr_sel;
    logic          cfg_wr, cmp_wr, route_wr;
    logic [CW-1:0] cfg_n, cmp_n, per_n;
    logic [CW-1:0] tgt_new;
    logic          wrap_new;
    logic [CW-1:0] arm_pt, nxt_tgt;
    logic          reached, ahead;

    assign wr_hi    = wr_addr_i[2];
    assign wr_sel   = reg_sel_e'(wr_addr_i[4:3]);
    assign cfg_wr   = wr_en_i && (wr_sel == RS_CFG) && !wr_hi;
    assign cmp_wr   = wr_en_i && (wr_sel == RS_CMP) && !(st_q.cfg[B_M32] && wr_hi);
    assign route_wr = wr_en_i && (wr_sel == RS_ROUTE);

    // register write merge
    always_comb begin
        logic [CW-1:0] cval, pval;
        cfg_n = st_q.cfg;
        cmp_n = st_q.cmp;
        per_n = st_q.per;
        cval  = '0;
        pval  = '0;
        if (cfg_wr) begin
            cfg_n = (st_q.cfg & ~CFG_WMASK) | ({{HW{1'b0}}, wr_data_i} & CFG_WMASK);
            if (cfg_n[B_M32]) begin
                cmp_n = low_only(st_q.cmp);
                per_n = low_only(st_q.per);
            end
        end
        if (cmp_wr) begin
            if (st_q.cfg[B_M32]) begin
                cval = {{HW{1'b0}}, wr_data_i};
                pval = cval;
            end else begin
                cval = put_half(st_q.cmp, wr_hi, wr_data_i);
                pval = put_half(st_q.per, wr_hi, wr_data_i);
            end
            if (!st_q.cfg[B_PER] || st_q.cfg[B_VSET]) cmp_n = cval;
            if (st_q.cfg[B_PER]) per_n = pval;
            cfg_n[B_VSET] = 1'b0;
        end
    end

    ctc_target #(.W(CW)) i_target (
        .cnt_i  (count_i),
        .cmp_i  (cmp_n),
        .m32_i  (cfg_n[B_M32]),
        .per_i  (cfg_n[B_PER]),
        .tgt_o  (tgt_new),
        .wrap_o (wrap_new)
    );

    assign arm_pt  = st_q.wrap ? {st_q.tgt[CW-1:HW], {HW{1'b0}}} : st_q.tgt;
    assign nxt_tgt = st_q.tgt + st_q.per;

    ctc_match #(.W(CW)) i_match (
        .cnt_i     (count_i),
        .arm_i     (arm_pt),
        .nxt_i     (nxt_tgt),
        .reached_o (reached),
        .ahead_o   (ahead)
    );

    ctc_rdmux i_rdmux (
        .addr_i  (rd_addr_i),
        .cfg_i   (st_q.cfg),
        .cmp_i   (st_q.cmp),
        .route_i (st_q.route),
        .data_o  (rd_data_o)
    );

    // next-state computation
    always_comb begin
        logic rearm, fire, ien_rise;
        logic [CW-1:0] vis_nxt;

        st_d     = st_q;
        st_d.cfg = cfg_n;
        st_d.cmp = cmp_n;
        st_d.per = per_n;
        st_d.gen = gbl_en_i;
        st_d.sts = 1'b0;
        if (route_wr) st_d.route = put_half(st_q.route, wr_hi, wr_data_i);

        rearm    = gbl_en_i && (cfg_wr || cmp_wr || !st_q.gen);
        fire     = gbl_en_i && st_q.armed && !st_q.adv && reached && !(cfg_wr || cmp_wr);
        ien_rise = cfg_wr && !st_q.cfg[B_IEN] && cfg_n[B_IEN];
        vis_nxt  = st_q.cfg[B_M32] ? low_only(nxt_tgt) : nxt_tgt;

        if (!gbl_en_i) begin
            st_d.armed = 1'b0;
            st_d.adv   = 1'b0;
            st_d.wrap  = 1'b0;
        end else if (rearm) begin
            st_d.tgt   = tgt_new;
            st_d.wrap  = wrap_new;
            st_d.armed = 1'b1;
            st_d.adv   = 1'b0;
        end else if (st_q.adv) begin
            st_d.tgt = nxt_tgt;
            st_d.cmp = vis_nxt;
            st_d.adv = !ahead;
        end else if (fire) begin
            if (st_q.cfg[B_PER] && (st_q.per != '0)) begin
                st_d.tgt = nxt_tgt;
                st_d.cmp = vis_nxt;
                st_d.adv = !ahead;
            end else if (st_q.wrap) begin
                st_d.wrap = 1'b0;
            end else begin
                st_d.armed = 1'b0;
            end
        end

        if (cfg_n[B_LVL]) begin
            st_d.irq = st_q.irq && st_q.cfg[B_LVL];
            if (sts_clr_i || !gbl_en_i) st_d.irq = 1'b0;
            if (gbl_en_i && cfg_n[B_IEN] && sts_pend_i && (ien_rise || !st_q.gen))
                st_d.irq = 1'b1;
            if (fire && st_q.cfg[B_IEN]) st_d.irq = 1'b1;
        end else begin
            st_d.irq = fire && st_q.cfg[B_IEN];
        end
        st_d.sts = fire && st_q.cfg[B_LVL];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.cfg   <= CFG_RST;
            st_q.cmp   <= '1;
            st_q.tgt   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = st_q.irq;
    assign sts_set_o = st_q.sts;
endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk
    import ctc_pkg::*;
(
    input logic          clk_i,
    input logic          rst_ni,
    input logic          gbl_en_i,
    input logic          sts_clr_i,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic          irq_o,
    input logic          sts_set_o,
    input logic [CW-1:0] cfg_i,
    input logic [CW-1:0] cmp_i,
    input logic [CW-1:0] per_i
);
    // R11
    irq_needs_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(gbl_en_i));

    // R4
    sts_level_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sts_set_o |-> $past(cfg_i[B_LVL]));

    // R9
    level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && cfg_i[B_LVL] && gbl_en_i && !sts_clr_i &&
         !(wr_en_i && wr_addr_i[4:3] == 2'd0)) |=> irq_o);

    // R7
    narrow_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_i[B_M32] |-> (cmp_i[CW-1:HW] == '0 && per_i[CW-1:HW] == '0));

    // R5
    vset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i[4:3] == 2'd1 && !(cfg_i[B_M32] && wr_addr_i[2]))
        |=> !cfg_i[B_VSET]);

    // R2
    cfg_hi_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i[4:3] == 2'd0) |=> $stable(cfg_i[CW-1:HW]));
endmodule

bind cmp_timer_chan cmp_timer_chan_chk i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gbl_en_i  (gbl_en_i),
    .sts_clr_i (sts_clr_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .irq_o     (irq_o),
    .sts_set_o (sts_set_o),
    .cfg_i     (st_q.cfg),
    .cmp_i     (st_q.cmp),
    .per_i     (st_q.per)
);

// File: tb/test_cmp_timer_chan.sv
module test_cmp_timer_chan;
    localparam logic [31:0] CAP = 32'h00F0_0000;
    localparam int NVEC = 7;
    // {write value, expected config low half}
    localparam logic [63:0] CFG_VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'h0000_7F7E},
        {32'h0000_0000, 32'h0000_0030},
        {32'h0000_0001, 32'h0000_0030},
        {32'h0000_0080, 32'h0000_0030},
        {32'h0000_4002, 32'h0000_4032},
        {32'h0000_010C, 32'h0000_013C},
        {32'h0000_2E00, 32'h0000_2E30}
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] count_i = '0;
    logic        gbl_en_i = 1'b0;
    logic        sts_pend_i = 1'b0;
    logic        sts_clr_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [4:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;
    logic        sts_set_o;

    int checks = 0;
    int errors = 0;

    always #4 clk_i = ~clk_i;

    cmp_timer_chan #(.ROUTE_CAP(CAP), .MSG_CAP(1'b0)) i_cmp_timer_chan (
        .clk_i, .rst_ni, .count_i, .gbl_en_i, .sts_pend_i, .sts_clr_i,
        .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
        .irq_o, .sts_set_o
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic set_cnt(input logic [63:0] v);
        @(negedge clk_i);
        count_i = v;
    endtask

    task automatic run(input int n, output int ip, output int sp,
                       output logic [63:0] first, output logic [63:0] last);
        ip = 0; sp = 0; first = '1; last = '1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            if (irq_o) begin
                if (ip == 0) first = count_i;
                last = count_i;
                ip++;
            end
            if (sts_set_o) sp++;
            count_i = count_i + 64'd1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int ip, sp;
        logic [63:0] fh, lh;

        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state
        rd(5'h00, d); chk("R1 cfg lo", {32'b0, d}, 64'h30);
        rd(5'h04, d); chk("R1 cfg hi", {32'b0, d}, {32'b0, CAP});
        rd(5'h08, d); chk("R1 cmp lo", {32'b0, d}, 64'hFFFF_FFFF);
        rd(5'h0C, d); chk("R1 cmp hi", {32'b0, d}, 64'hFFFF_FFFF);
        rd(5'h10, d); chk("R1 route", {32'b0, d}, 64'h0);
        chk("R1 irq", {63'b0, irq_o}, 64'h0);
        chk("R1 sts", {63'b0, sts_set_o}, 64'h0);

        // R2 write mask table
        for (int k = 0; k < NVEC; k++) begin
            wr(5'h00, CFG_VEC[k][63:32]);
            rd(5'h00, d);
            chk("R2 cfg mask", {32'b0, d}, {32'b0, CFG_VEC[k][31:0]});
        end
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, d); chk("R2 cfg hi read-only", {32'b0, d}, {32'b0, CAP});
        wr(5'h00, 32'h0);

        // R3 one-shot 64-bit edge
        set_cnt(64'h50);
        @(negedge clk_i); gbl_en_i = 1'b1;
        wr(5'h08, 32'h100);
        wr(5'h0C, 32'h0);
        wr(5'h00, 32'h4);
        set_cnt(64'hF0);
        run(32'h30, ip, sp, fh, lh);
        chk("R3 pulse count", ip, 1);
        chk("R3 hit point", fh, 64'h100);
        chk("R4 edge no sts", sp, 0);

        // R4 level with interrupt disabled
        wr(5'h08, 32'h200);
        wr(5'h00, 32'h2);
        set_cnt(64'h1F0);
        run(32'h20, ip, sp, fh, lh);
        chk("R4 sts pulse", sp, 1);
        chk("R4 no irq", ip, 0);

        // R5 periodic loads
        wr(5'h08, 32'h300);
        wr(5'h00, 32'h4C);
        wr(5'h08, 32'h300);
        rd(5'h00, d); chk("R5 value-set cleared", {32'b0, d}, 64'h3C);
        wr(5'h08, 32'h40);
        rd(5'h08, d); chk("R5 cmp kept", {32'b0, d}, 64'h300);

        // R6 periodic repeats
        set_cnt(64'h2F0);
        run(32'h98, ip, sp, fh, lh);
        chk("R6 pulses", ip, 3);
        chk("R6 first", fh, 64'h300);
        chk("R6 last", lh, 64'h380);
        rd(5'h08, d); chk("R6 visible cmp", {32'b0, d}, 64'h3C0);

        // R7 32-bit mode
        wr(5'h00, 32'h4);
        wr(5'h0C, 32'h5);
        rd(5'h0C, d); chk("R7 hi before", {32'b0, d}, 64'h5);
        set_cnt(64'h1_0000_0050);
        wr(5'h00, 32'h104);
        rd(5'h0C, d); chk("R7 hi truncated", {32'b0, d}, 64'h0);
        wr(5'h0C, 32'h7);
        rd(5'h0C, d); chk("R7 hi write ignored", {32'b0, d}, 64'h0);
        rd(5'h08, d); chk("R7 lo kept", {32'b0, d}, 64'h3C0);
        wr(5'h08, 32'h80);
        run(32'h40, ip, sp, fh, lh);
        chk("R7 pulses", ip, 1);
        chk("R7 spliced target", fh, 64'h1_0000_0080);

        // R8 rollover extra event
        wr(5'h08, 32'h10);
        set_cnt(64'h1_FFFF_FFF0);
        run(32'h30, ip, sp, fh, lh);
        chk("R8 pulses", ip, 2);
        chk("R8 rollover hit", fh, 64'h2_0000_0000);
        chk("R8 target hit", lh, 64'h2_0000_0010);

        // R9 level hold and clear
        set_cnt(64'h0);
        wr(5'h00, 32'h6);
        run(32'h20, ip, sp, fh, lh);
        chk("R9 level held", {63'b0, irq_o}, 64'h1);
        chk("R9 sts pulse", sp, 1);
        @(negedge clk_i); sts_clr_i = 1'b1;
        @(negedge clk_i); sts_clr_i = 1'b0;
        chk("R9 cleared", {63'b0, irq_o}, 64'h0);
        wr(5'h08, 32'h30);
        run(32'h20, ip, sp, fh, lh);
        chk("R9 level again", {63'b0, irq_o}, 64'h1);
        wr(5'h00, 32'h4);
        chk("R9 level to edge drops", {63'b0, irq_o}, 64'h0);

        // R10 enable with pending status
        sts_pend_i = 1'b1;
        set_cnt(64'h0);
        wr(5'h00, 32'h2);
        chk("R10 no irq while disabled", {63'b0, irq_o}, 64'h0);
        wr(5'h00, 32'h6);
        chk("R10 immediate irq", {63'b0, irq_o}, 64'h1);

        // R11 global enable
        @(negedge clk_i); gbl_en_i = 1'b0;
        @(negedge clk_i);
        chk("R11 drop on disable", {63'b0, irq_o}, 64'h0);
        sts_pend_i = 1'b0;
        set_cnt(64'h20);
        run(32'h20, ip, sp, fh, lh);
        chk("R11 no irq disabled", ip, 0);
        chk("R11 no sts disabled", sp, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule